// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block computes, for a single memory load or store, the byte address the transfer uses and the value the base register holds once the transfer is done. It is purely combinational. It takes a base register value and one offset. The offset is either an immediate or a register value that may be shifted. The offset can be added to the base or subtracted from it. The block then applies one of two indexing modes:

- In pre-indexed mode, the transfer uses the adjusted address. That address is written back to the base only when writeback is requested.
- In post-indexed mode, the transfer uses the unmodified base. The adjusted value is always written back.

The block also checks that the offset form is legal for the access size. Word and unsigned-byte accesses accept a 12-bit immediate or a register offset shifted in any of four ways. Halfword and signed accesses accept only an 8-bit immediate or an unshifted register. An illegal request raises an error and blocks writeback. All arithmetic wraps modulo 2^32.

Top module: `addr_gen`

## Requirements
- R1: With `pre_i`=1, `addr_o` equals `base_i` plus the offset when `add_i`=1, and `base_i` minus the offset when `add_i`=0.
- R2: With `pre_i`=1 and no error, `wb_en_o` equals `wb_i`. When `wb_en_o`=1, `base_new_o` equals `addr_o`; otherwise `base_new_o` equals `base_i`.
- R3: With `pre_i`=0 and no error, `addr_o` equals `base_i`, `wb_en_o`=1, and `base_new_o` is `base_i` plus or minus the offset, whatever `wb_i` is.
- R4: Subtraction applies to both the immediate and the register offset forms. For example, a pre-indexed byte store with writeback, `base_i`=0x8000, immediate 1 and subtract gives address 0x7FFF and new base 0x7FFF.
- R5: For word (`size_i`=0) and unsigned byte (`size_i`=1), an immediate offset (`off_reg_i`=0) is `imm_i` zero-extended from 12 bits.
- R6: For halfword (2), signed halfword (3) and signed byte (4), an immediate offset is `imm_i[7:0]`. A nonzero `imm_i[11:8]` sets `err_o`.
- R7: A register offset (`off_reg_i`=1) is `rm_i` shifted by `shift_amt_i` according to `shift_type_i`: 0=LSL, 1=LSR, 2=ASR, 3=ROR. ROR by 0 leaves the value unchanged.
- R8: An LSR or ASR with amount 0 shifts by 32. LSR then yields 0, and ASR yields 32 copies of `rm_i[31]`.
- R9: For halfword and signed sizes, a register offset with a nonzero amount or a shift type other than LSL sets `err_o`.
- R10: When `err_o`=1, `wb_en_o`=0 and `base_new_o` equals `base_i`.
- R11: Sums and differences wrap modulo 2^32.
- R12: `size_i` codes 5 to 7 set `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Immediate offset |
| rm_i | input | 32 | Register offset value before shifting |
| off_reg_i | input | 1 | 1 selects the register offset, 0 selects the immediate |
| shift_type_i | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_amt_i | input | 5 | Shift amount |
| add_i | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_i | input | 1 | 1 pre-indexed, 0 post-indexed |
| wb_i | input | 1 | Writeback request for pre-indexed mode |
| size_i | input | 3 | 0 word, 1 unsigned byte, 2 halfword, 3 signed halfword, 4 signed byte |
| addr_o | output | 32 | Transfer address |
| base_new_o | output | 32 | Base value after the access |
| wb_en_o | output | 1 | Base register write enable |
| err_o | output | 1 | Illegal offset form for this access size |

## Verification
The checker watches the writeback contract at every input change:

- An error blocks writeback and leaves the base unchanged.
- A post-indexed access addresses the raw base and always writes back.
- A pre-indexed writeback returns the address itself.
- A wide halfword immediate always raises an error.

Only the bench scenarios can show that the shifted offset values are right. This covers the zero-amount cases that shift by 32 and the rotations, the wrap-around at the top of the address space, and the decrement-by-one store.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
    localparam int unsigned XLEN     = 32;
    localparam int unsigned IMM_W    = 12;
    localparam int unsigned NARROW_W = 8;
    localparam int unsigned SAMT_W   = 5;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_e;

    typedef enum logic [2:0] {
        SZ_WORD  = 3'd0,
        SZ_UBYTE = 3'd1,
        SZ_HALF  = 3'd2,
        SZ_SHALF = 3'd3,
        SZ_SBYTE = 3'd4
    } size_e;
endpackage

// File: rtl/agen_shift.sv
module agen_shift
    import addr_gen_pkg::*;
#(
    parameter int unsigned W   = XLEN,
    parameter int unsigned AW  = SAMT_W
) (
    input  logic [W-1:0]  val_i,
    input  logic [1:0]    kind_i,
    input  logic [AW-1:0] amt_i,
    output logic [W-1:0]  res_o
);
    localparam int unsigned DW = 2 * W;

    logic [DW-1:0] dbl;

    always_comb begin
        dbl   = '0;
        res_o = val_i;
        unique case (shift_e'(kind_i))
            SH_LSL: res_o = val_i << amt_i;
            SH_LSR: res_o = (amt_i == '0) ? '0 : (val_i >> amt_i);
            SH_ASR: res_o = (amt_i == '0) ? {W{val_i[W-1]}}
                                          : W'($signed(val_i) >>> amt_i);
            SH_ROR: begin
                dbl   = {val_i, val_i} >> amt_i;
                res_o = dbl[W-1:0];
            end
            default: res_o = val_i;
        endcase
    end
endmodule

// File: rtl/agen_legal.sv
module agen_legal
    import addr_gen_pkg::*;
#(
    parameter int unsigned W   = XLEN,
    parameter int unsigned IW  = IMM_W,
    parameter int unsigned NW  = NARROW_W,
    parameter int unsigned AW  = SAMT_W
) (
    input  logic [2:0]    size_i,
    input  logic          off_reg_i,
    input  logic [1:0]    kind_i,
    input  logic [AW-1:0] amt_i,
    input  logic [IW-1:0] imm_i,
    output logic [W-1:0]  imm_ext_o,
    output logic          err_o
);
    logic wide_ok;
    logic narrow_ok;

    always_comb begin
        wide_ok   = 1'b0;
        narrow_ok = 1'b0;
        unique case (size_i)
            SZ_WORD, SZ_UBYTE:           wide_ok   = 1'b1;
            SZ_HALF, SZ_SHALF, SZ_SBYTE: narrow_ok = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        if (wide_ok) begin
            imm_ext_o = W'(imm_i);
            err_o     = 1'b0;
        end else if (narrow_ok) begin
            imm_ext_o = W'(imm_i[NW-1:0]);
            if (off_reg_i)
                err_o = (amt_i != '0) || (shift_e'(kind_i) != SH_LSL);
            else
                err_o = (imm_i[IW-1:NW] != '0);
        end else begin
            imm_ext_o = W'(imm_i[NW-1:0]);
            err_o     = 1'b1;
        end
    end
endmodule

// File: rtl/agen_sum.sv
module agen_sum
    import addr_gen_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] off_i,
    input  logic         add_i,
    input  logic         pre_i,
    input  logic         wb_i,
    input  logic         err_i,
    output logic [W-1:0] addr_o,
    output logic [W-1:0] base_new_o,
    output logic         wb_en_o
);
    logic [W-1:0] moved;

    always_comb begin
        moved   = add_i ? (base_i + off_i) : (base_i - off_i);
        addr_o  = pre_i ? moved : base_i;
        wb_en_o = !err_i && (wb_i || !pre_i);
        base_new_o = wb_en_o ? moved : base_i;
    end
endmodule

// File: rtl/addr_gen.sv
module addr_gen
    import addr_gen_pkg::*;
(
    input  logic [31:0] base_i,
    input  logic [11:0] imm_i,
    input  logic [31:0] rm_i,
    input  logic        off_reg_i,
    input  logic [1:0]  shift_type_i,
    input  logic [4:0]  shift_amt_i,
    input  logic        add_i,
    input  logic        pre_i,
    input  logic        wb_i,
    input  logic [2:0]  size_i,
    output logic [31:0] addr_o,
    output logic [31:0] base_new_o,
    output logic        wb_en_o,
    output logic        err_o
);
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] offset;

    agen_shift #(.W(XLEN), .AW(SAMT_W)) i_shift (
        .val_i  (rm_i),
        .kind_i (shift_type_i),
        .amt_i  (shift_amt_i),
        .res_o  (shifted)
    );

    agen_legal #(.W(XLEN), .IW(IMM_W), .NW(NARROW_W), .AW(SAMT_W)) i_legal (
        .size_i    (size_i),
        .off_reg_i (off_reg_i),
        .kind_i    (shift_type_i),
        .amt_i     (shift_amt_i),
        .imm_i     (imm_i),
        .imm_ext_o (imm_ext),
        .err_o     (err_o)
    );

    assign offset = off_reg_i ? shifted : imm_ext;

    agen_sum #(.W(XLEN)) i_sum (
        .base_i     (base_i),
        .off_i      (offset),
        .add_i      (add_i),
        .pre_i      (pre_i),
        .wb_i       (wb_i),
        .err_i      (err_o),
        .addr_o     (addr_o),
        .base_new_o (base_new_o),
        .wb_en_o    (wb_en_o)
    );
endmodule

// File: rtl/agen_chk.sv
module agen_chk (
    input logic [31:0] base_i,
    input logic [11:0] imm_i,
    input logic        off_reg_i,
    input logic        pre_i,
    input logic        wb_i,
    input logic [2:0]  size_i,
    input logic [31:0] addr_o,
    input logic [31:0] base_new_o,
    input logic        wb_en_o,
    input logic        err_o
);
    always_comb begin
        if (err_o) begin
            a_r10_err_blocks_wb: assert (!wb_en_o && base_new_o == base_i);
        end
        if (!pre_i && !err_o) begin
            a_r3_post_raw_addr: assert (addr_o == base_i && wb_en_o);
        end
        if (pre_i && wb_en_o) begin
            a_r2_pre_wb_value: assert (base_new_o == addr_o);
        end
        if (pre_i && !wb_i) begin
            a_r2_pre_no_wb: assert (!wb_en_o && base_new_o == base_i);
        end
        if (!off_reg_i && size_i >= 3'd2 && size_i <= 3'd4 && imm_i[11:8] != 4'd0) begin
            a_r6_wide_imm_err: assert (err_o);
        end
        if (size_i > 3'd4) begin
            a_r12_bad_size: assert (err_o);
        end
    end
endmodule

bind addr_gen agen_chk i_chk (
    .base_i     (base_i),
    .imm_i      (imm_i),
    .off_reg_i  (off_reg_i),
    .pre_i      (pre_i),
    .wb_i       (wb_i),
    .size_i     (size_i),
    .addr_o     (addr_o),
    .base_new_o (base_new_o),
    .wb_en_o    (wb_en_o),
    .err_o      (err_o)
);

// File: tb/test_addr_gen.sv
module test_addr_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [31:0] base, rm;
    logic [11:0] imm;
    logic        oreg, add, pre, wb;
    logic [1:0]  sty;
    logic [4:0]  samt;
    logic [2:0]  size;
    logic [31:0] addr, bnew;
    logic        wben, err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    addr_gen i_addr_gen (
        .base_i(base), .imm_i(imm), .rm_i(rm), .off_reg_i(oreg),
        .shift_type_i(sty), .shift_amt_i(samt), .add_i(add), .pre_i(pre),
        .wb_i(wb), .size_i(size), .addr_o(addr), .base_new_o(bnew),
        .wb_en_o(wben), .err_o(err)
    );

    function automatic logic [31:0] m_off(logic [31:0] r, logic [1:0] t, logic [4:0] n,
                                          logic o, logic [11:0] im, logic [2:0] sz);
        logic [63:0] x;
        int k;
        k = (n == 0 && (t == 1 || t == 2)) ? 32 : int'(n);
        if (!o) return (sz <= 1) ? {20'd0, im} : {24'd0, im[7:0]};
        case (t)
            2'd0: x = {32'd0, r} << k;
            2'd1: x = {32'd0, r} >> k;
            2'd2: x = {{32{r[31]}}, r} >> k;
            default: x = {r, r} >> k;
        endcase
        return x[31:0];
    endfunction

    function automatic logic m_err(logic o, logic [11:0] im, logic [1:0] t,
                                   logic [4:0] n, logic [2:0] sz);
        if (sz <= 1) return 1'b0;
        if (sz > 4) return 1'b1;
        if (o) return (t != 0 || n != 0);
        return im[11:8] != 0;
    endfunction

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(string tag);
        logic [31:0] o, mv, ea, bn;
        logic e, we;
        @(posedge clk);
        @(negedge clk);
        o  = m_off(rm, sty, samt, oreg, imm, size);
        e  = m_err(oreg, imm, sty, samt, size);
        mv = add ? base + o : base - o;
        ea = pre ? mv : base;
        we = !e && (!pre || wb);
        bn = we ? mv : base;
        cmp({tag, " err"}, {31'd0, err}, {31'd0, e});
        cmp({tag, " addr"}, addr, ea);
        cmp({tag, " wb_en"}, {31'd0, wben}, {31'd0, we});
        cmp({tag, " base_new"}, bnew, bn);
    endtask

    task automatic set(logic [31:0] b, logic [11:0] i, logic [31:0] r, logic o,
                       logic [1:0] t, logic [4:0] n, logic a, logic p, logic w, logic [2:0] s);
        base = b; imm = i; rm = r; oreg = o; sty = t; samt = n;
        add = a; pre = p; wb = w; size = s;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        set(0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        repeat (2) @(posedge clk);
        rst = 1'b0;
        run("R1 R5 idle-zero");
        set(32'h1000_0008, 12'd8, 0, 0, 0, 0, 1, 1, 1, 0); run("R1 R2 pre wb");
        set(32'h1000_0008, 12'd8, 0, 0, 0, 0, 1, 1, 0, 0); run("R2 pre no wb");
        set(32'h8000, 12'd4, 0, 0, 0, 0, 1, 0, 0, 0);      run("R3 post forced wb");
        set(32'h8000, 12'd1, 0, 0, 0, 0, 0, 1, 1, 1);      run("R4 byte minus one");
        set(32'h100, 0, 32'd3, 1, 0, 5'd2, 0, 1, 1, 0);    run("R4 reg subtract");
        set(32'h0, 12'hF1A, 0, 0, 0, 0, 1, 1, 0, 1);       run("R5 wide imm");
        set(32'h0, 12'h0F4, 0, 0, 0, 0, 1, 1, 1, 2);       run("R6 narrow imm ok");
        set(32'h0, 12'h1F4, 0, 0, 0, 0, 1, 1, 1, 3);       run("R6 narrow imm wide err");
        set(32'h0, 0, 32'h1234_5678, 1, 3, 5'd8, 1, 1, 0, 0); run("R7 ror8");
        set(32'h0, 0, 32'h1, 1, 0, 5'd28, 1, 1, 0, 0);     run("R7 lsl28");
        set(32'h0, 0, 32'h1234_5678, 1, 3, 5'd0, 1, 1, 0, 0); run("R7 ror0");
        set(32'h40, 0, 32'h8000_0000, 1, 1, 5'd0, 1, 1, 0, 0); run("R8 lsr32");
        set(32'h40, 0, 32'h8000_0000, 1, 2, 5'd0, 1, 1, 0, 0); run("R8 asr32");
        set(32'h40, 0, 32'h8000_0000, 1, 2, 5'd4, 1, 1, 0, 0); run("R7 asr4");
        set(32'h0, 0, 32'h4, 1, 0, 5'd2, 1, 0, 1, 4);      run("R9 R10 sbyte scaled");
        set(32'h0, 0, 32'h4, 1, 1, 5'd0, 1, 1, 1, 2);      run("R9 half lsr");
        set(32'h10, 0, 32'h4, 1, 0, 5'd0, 1, 0, 0, 2);     run("R9 half plain reg");
        set(32'hFFFF_FFFC, 12'd8, 0, 0, 0, 0, 1, 1, 1, 0); run("R11 wrap up");
        set(32'h4, 12'd8, 0, 0, 0, 0, 0, 0, 0, 0);         run("R11 wrap down");
        set(32'h1234, 12'd4, 0, 0, 0, 0, 1, 0, 1, 6);      run("R12 R10 bad size");
        for (int i = 0; i < 600; i++) begin
            logic [2:0] s;
            s = ($urandom % 8 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
            set($urandom, ($urandom % 2) ? 12'($urandom) : 12'($urandom % 256),
                $urandom, 1'($urandom), ($urandom % 3 == 0) ? 2'd0 : 2'($urandom),
                ($urandom % 3 == 0) ? 5'd0 : 5'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), s);
            run("R1 R3 R7 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule